// File: doc/BRIEF.md
# Highest Priority Interrupt Selector

This block sits between an interrupt distributor's state arrays and the interrupt request lines of up to eight processors. For every processor it searches all interrupt IDs that could reach that processor and picks the most urgent one that is both pending and enabled. Its outputs are the winning ID and a request line. IDs 0 to 15 are software interrupts and IDs 16 to 31 are private peripheral interrupts. Both are banked, so each processor has its own copy of their pending, enable and priority state. IDs from 32 upward are shared peripheral interrupts with one global copy of their state, and each of them carries an 8-bit mask naming the processors it may be delivered to.

Priorities are 8-bit values, and a smaller number is more urgent. Each processor supplies a priority mask, and only interrupts strictly more urgent than that mask are considered. Equal priorities go to the lowest ID. When nothing qualifies, the recorded ID is 1023, the spurious code. The chosen ID is recorded whatever the enable flags are. The request line also needs the global distributor enable and that processor's interface enable.

Top module: `irq_prio_select`

## Requirements
- R1: While rst_n is low at a clock edge, every hi_id field becomes 1023 and every irq_req bit becomes 0.
- R2: Among qualifying candidates for a processor, the one with the numerically smallest 8-bit priority is chosen.
- R3: A candidate qualifies only when its pending bit and its enable bit are both 1.
- R4: When qualifying candidates share the smallest priority, the lowest ID wins, across all three classes.
- R5: Shared interrupt 32+k qualifies for processor c only when bit c of spi_tgt[k*8 +: 8] is 1.
- R6: A candidate qualifies only when its priority is strictly less than cpu_pmask[c*8 +: 8]. A priority of 0xff is therefore never chosen.
- R7: When no candidate qualifies for processor c, hi_id[c*10 +: 10] is 1023 and irq_req[c] is 0.
- R8: irq_req[c] is 1 exactly when a candidate qualifies, dist_en is 1 and cpu_en[c] is 1.
- R9: Both outputs are registered and reflect the inputs present at the previous rising clock edge. Between edges they hold.
- R10: For processor c, IDs 0..31 use only its own banked bits, at index c*32+id of priv_pend and priv_en and at priv_prio[(c*32+id)*8 +: 8].
- R11: hi_id records the selected ID even when dist_en or cpu_en[c] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | NUM_CPU | Per-processor interface enable |
| cpu_pmask | input | NUM_CPU*8 | Per-processor priority mask |
| priv_pend | input | NUM_CPU*32 | Banked pending bits, IDs 0..31 |
| priv_en | input | NUM_CPU*32 | Banked enable bits, IDs 0..31 |
| priv_prio | input | NUM_CPU*32*8 | Banked priorities, IDs 0..31 |
| spi_pend | input | NUM_SHARED | Shared pending bits, ID 32+k at bit k |
| spi_en | input | NUM_SHARED | Shared enable bits |
| spi_prio | input | NUM_SHARED*8 | Shared priorities |
| spi_tgt | input | NUM_SHARED*8 | Shared target masks, one bit per processor |
| irq_req | output | NUM_CPU | Per-processor interrupt request |
| hi_id | output | NUM_CPU*10 | Per-processor selected ID, 1023 when none |

## Verification
The request line and the recorded ID are both due exactly one rising edge after the inputs that cause them. The bench changes inputs on the falling edge and computes the expected result for each processor from its own model at that moment. It compares the outputs on the next falling edge, after the single register stage has captured them. Just after each input change it also confirms that the outputs still show the previous result, so nothing leaks through combinationally.

// File: rtl/irq_sel_pkg.sv
// Shared constants and types for the highest priority interrupt selector.
// Assumes 8-bit priorities and a 10-bit interrupt ID space.
package irq_sel_pkg;
    localparam int PRIO_W   = 8;
    localparam int ID_W     = 10;
    localparam int PRIV_N   = 32;   // banked IDs 0..31 (software + private)
    localparam int SPURIOUS = 1023;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ID_W-1:0]   id_t;
endpackage

// File: rtl/irq_cand_build.sv
// Builds the candidate list of one processor: a qualify bit and a priority
// for every ID, banked IDs first, then shared IDs filtered by the target mask.
// Assumes CPU_IDX < 8 so that it indexes into the 8-bit target byte.
module irq_cand_build
    import irq_sel_pkg::*;
#(
    parameter int CPU_IDX    = 0,
    parameter int NUM_SHARED = 32,
    localparam int TOTAL     = PRIV_N + NUM_SHARED
) (
    input  logic [PRIV_N-1:0]            bank_pend,
    input  logic [PRIV_N-1:0]            bank_en,
    input  logic [PRIV_N*PRIO_W-1:0]     bank_prio,
    input  logic [NUM_SHARED-1:0]        spi_pend,
    input  logic [NUM_SHARED-1:0]        spi_en,
    input  logic [NUM_SHARED*PRIO_W-1:0] spi_prio,
    input  logic [NUM_SHARED*8-1:0]      spi_tgt,
    output logic [TOTAL-1:0]             cand_vld,
    output logic [TOTAL*PRIO_W-1:0]      cand_prio
);
    // Banked entries: pending and enabled from this processor's own copy.
    genvar i;
    generate
        for (i = 0; i < PRIV_N; i++) begin : g_bank
            assign cand_vld[i] = bank_pend[i] & bank_en[i];
            assign cand_prio[i*PRIO_W +: PRIO_W] = bank_prio[i*PRIO_W +: PRIO_W];
        end
        // Shared entries: also need this processor's bit in the target byte.
        for (i = 0; i < NUM_SHARED; i++) begin : g_shared
            assign cand_vld[PRIV_N+i] = spi_pend[i] & spi_en[i] & spi_tgt[i*8 + CPU_IDX];
            assign cand_prio[(PRIV_N+i)*PRIO_W +: PRIO_W] = spi_prio[i*PRIO_W +: PRIO_W];
        end
    endgenerate
endmodule

// File: rtl/irq_prio_scan.sv
// Scans candidates in ascending ID order and keeps the first one whose
// priority is strictly below the running best, starting from the threshold.
// Assumes N fits the ID space below the spurious code.
module irq_prio_scan
    import irq_sel_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]        cand_vld,
    input  logic [N*PRIO_W-1:0] cand_prio,
    input  prio_t               thresh,
    output logic                sel_vld,
    output id_t                 sel_id,
    output prio_t               sel_prio
);
    // Linear strict-less scan; the lowest ID keeps a tie.
    always_comb begin
        sel_vld  = 1'b0;
        sel_id   = id_t'(SPURIOUS);
        sel_prio = thresh;
        for (int k = 0; k < N; k++) begin
            if (cand_vld[k] && (cand_prio[k*PRIO_W +: PRIO_W] < sel_prio)) begin
                sel_vld  = 1'b1;
                sel_id   = id_t'(k);
                sel_prio = cand_prio[k*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_cpu_port.sv
// Output register stage of one processor: holds the selected ID and drives
// the request line when both enables allow it. Synchronous active-low reset.
module irq_cpu_port
    import irq_sel_pkg::*;
#(
    parameter int TOTAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dist_en,
    input  logic cpu_en,
    input  logic sel_vld,
    input  id_t  sel_id,
    output id_t  hi_id,
    output logic irq_req
);
    // Capture the selection and gate the request with both enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_id   <= id_t'(SPURIOUS);
            irq_req <= 1'b0;
        end else begin
            hi_id   <= sel_vld ? sel_id : id_t'(SPURIOUS);
            irq_req <= sel_vld & dist_en & cpu_en;
        end
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(dist_en && cpu_en));
    // R7
    irq_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (hi_id != id_t'(SPURIOUS)));
    // R9
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_id == id_t'(SPURIOUS)) || (int'(hi_id) < TOTAL));
endmodule

// File: rtl/irq_prio_select.sv
// Top: per-processor highest priority interrupt selection over banked
// software/private IDs 0..31 and shared IDs 32 upward.
// Assumes NUM_CPU <= 8 and 32 + NUM_SHARED <= 1020.
module irq_prio_select
    import irq_sel_pkg::*;
#(
    parameter int NUM_CPU    = 2,
    parameter int NUM_SHARED = 32,
    localparam int TOTAL     = PRIV_N + NUM_SHARED
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dist_en,
    input  logic [NUM_CPU-1:0]            cpu_en,
    input  logic [NUM_CPU*PRIO_W-1:0]     cpu_pmask,
    input  logic [NUM_CPU*PRIV_N-1:0]     priv_pend,
    input  logic [NUM_CPU*PRIV_N-1:0]     priv_en,
    input  logic [NUM_CPU*PRIV_N*PRIO_W-1:0] priv_prio,
    input  logic [NUM_SHARED-1:0]         spi_pend,
    input  logic [NUM_SHARED-1:0]         spi_en,
    input  logic [NUM_SHARED*PRIO_W-1:0]  spi_prio,
    input  logic [NUM_SHARED*8-1:0]       spi_tgt,
    output logic [NUM_CPU-1:0]            irq_req,
    output logic [NUM_CPU*ID_W-1:0]       hi_id
);
    genvar c;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic [TOTAL-1:0]        cand_vld;
            logic [TOTAL*PRIO_W-1:0] cand_prio;
            logic                    sel_vld;
            id_t                     sel_id;
            prio_t                   sel_prio;
            id_t                     id_q;
            prio_t                   pmask;

            assign pmask = cpu_pmask[c*PRIO_W +: PRIO_W];

            irq_cand_build #(.CPU_IDX(c), .NUM_SHARED(NUM_SHARED)) u_build (
                .bank_pend (priv_pend[c*PRIV_N +: PRIV_N]),
                .bank_en   (priv_en[c*PRIV_N +: PRIV_N]),
                .bank_prio (priv_prio[c*PRIV_N*PRIO_W +: PRIV_N*PRIO_W]),
                .spi_pend  (spi_pend),
                .spi_en    (spi_en),
                .spi_prio  (spi_prio),
                .spi_tgt   (spi_tgt),
                .cand_vld  (cand_vld),
                .cand_prio (cand_prio)
            );

            irq_prio_scan #(.N(TOTAL)) u_scan (
                .cand_vld  (cand_vld),
                .cand_prio (cand_prio),
                .thresh    (pmask),
                .sel_vld   (sel_vld),
                .sel_id    (sel_id),
                .sel_prio  (sel_prio)
            );

            irq_cpu_port #(.TOTAL(TOTAL)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .dist_en (dist_en),
                .cpu_en  (cpu_en[c]),
                .sel_vld (sel_vld),
                .sel_id  (sel_id),
                .hi_id   (id_q),
                .irq_req (irq_req[c])
            );

            assign hi_id[c*ID_W +: ID_W] = id_q;

            // R6
            below_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel_vld |-> (sel_prio < pmask));
            // R3
            sel_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sel_vld |-> cand_vld[sel_id]);
        end
    endgenerate
endmodule

// File: tb/irq_prio_select_test.sv
module irq_prio_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 2;
    localparam int NS  = 32;
    localparam int TOT = 32 + NS;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              dist_en;
    logic [NC-1:0]     cpu_en;
    logic [NC*8-1:0]   cpu_pmask;
    logic [NC*32-1:0]  priv_pend, priv_en;
    logic [NC*256-1:0] priv_prio;
    logic [NS-1:0]     spi_pend, spi_en;
    logic [NS*8-1:0]   spi_prio, spi_tgt;
    logic [NC-1:0]     irq_req;
    logic [NC*10-1:0]  hi_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int prev_id [NC];
    bit prev_rq [NC];
    bit have_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_select #(.NUM_CPU(NC), .NUM_SHARED(NS)) uut (
        .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
        .cpu_pmask(cpu_pmask), .priv_pend(priv_pend), .priv_en(priv_en),
        .priv_prio(priv_prio), .spi_pend(spi_pend), .spi_en(spi_en),
        .spi_prio(spi_prio), .spi_tgt(spi_tgt), .irq_req(irq_req), .hi_id(hi_id)
    );

    function automatic int prio_of(int c, int id);
        if (id < 32) return int'(priv_prio[(c*32+id)*8 +: 8]);
        return int'(spi_prio[(id-32)*8 +: 8]);
    endfunction

    function automatic bit qual(int c, int id);
        bit ok;
        if (id < 32) ok = priv_pend[c*32+id] && priv_en[c*32+id];
        else ok = spi_pend[id-32] && spi_en[id-32] && spi_tgt[(id-32)*8 + c];
        return ok && (prio_of(c, id) < int'(cpu_pmask[c*8 +: 8]));
    endfunction

    // Reference: find the minimum qualifying priority, then its first ID.
    function automatic int model_id(int c);
        int minp = 256;
        if (!rst_n) return 1023;
        for (int i = 0; i < TOT; i++)
            if (qual(c, i) && prio_of(c, i) < minp) minp = prio_of(c, i);
        for (int i = 0; i < TOT; i++)
            if (qual(c, i) && prio_of(c, i) == minp) return i;
        return 1023;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply-then-check: inputs were just changed at a falling edge.
    task automatic step(string tag);
        int eid [NC];
        bit erq [NC];
        #1;
        if (have_prev)
            for (int c = 0; c < NC; c++) begin
                chk("R9 hold id", int'(hi_id[c*10 +: 10]), prev_id[c]);
                chk("R9 hold irq", int'(irq_req[c]), int'(prev_rq[c]));
            end
        for (int c = 0; c < NC; c++) begin
            eid[c] = model_id(c);
            erq[c] = rst_n && (eid[c] != 1023) && dist_en && cpu_en[c];
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            chk({tag, " id"}, int'(hi_id[c*10 +: 10]), eid[c]);
            chk({tag, " irq"}, int'(irq_req[c]), int'(erq[c]));
            prev_id[c] = eid[c];
            prev_rq[c] = erq[c];
        end
        have_prev = 1;
    endtask

    task automatic clear_all();
        dist_en = 1; cpu_en = '1; cpu_pmask = '1;
        priv_pend = '0; priv_en = '0; priv_prio = {NC*32{8'hA0}};
        spi_pend = '0; spi_en = '0; spi_prio = {NS{8'hA0}}; spi_tgt = '0;
    endtask

    task automatic set_priv(int c, int id, int p);
        priv_pend[c*32+id] = 1; priv_en[c*32+id] = 1;
        priv_prio[(c*32+id)*8 +: 8] = 8'(p);
    endtask

    task automatic set_spi(int id, int p, int tgt);
        spi_pend[id-32] = 1; spi_en[id-32] = 1;
        spi_prio[(id-32)*8 +: 8] = 8'(p); spi_tgt[(id-32)*8 +: 8] = 8'(tgt);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_all();
        rst_n = 0;
        set_priv(0, 3, 8'h10); set_spi(40, 8'h10, 8'h03);
        @(posedge clk); @(negedge clk);
        step("R1 reset");
        step("R1 reset hold");

        rst_n = 1; clear_all();
        step("R7 empty");

        // R2: priority beats order
        set_priv(0, 3, 8'h80); set_priv(0, 20, 8'h40);
        step("R2 ppi beats sgi");
        set_spi(50, 8'h20, 8'h01);
        step("R2 spi wins");

        // R3: pending or enable alone
        clear_all();
        priv_pend[0*32+7] = 1; priv_prio[7*8 +: 8] = 8'h05;
        spi_en[5] = 1; spi_tgt[5*8 +: 8] = 8'hFF; spi_prio[5*8 +: 8] = 8'h05;
        set_priv(0, 9, 8'h90);
        step("R3 needs both");

        // R4: ties go to lowest ID
        clear_all();
        set_priv(0, 5, 8'h30); set_spi(40, 8'h30, 8'h01);
        set_spi(34, 8'h50, 8'h02); set_spi(33, 8'h50, 8'h02);
        step("R4 tie");

        // R5: target filtering
        clear_all();
        set_spi(40, 8'h10, 8'h02);
        step("R5 target cpu1");
        spi_tgt[8*8 +: 8] = 8'h01;
        step("R5 target cpu0");

        // R6: mask threshold
        clear_all();
        set_priv(0, 4, 8'h40); cpu_pmask[7:0] = 8'h40;
        set_priv(1, 4, 8'hFF);
        step("R6 equal to mask");
        cpu_pmask[7:0] = 8'h41;
        step("R6 below mask");

        // R8 and R11: gating leaves ID recorded
        clear_all();
        set_priv(0, 12, 8'h10); set_priv(1, 25, 8'h10);
        dist_en = 0;
        step("R11 dist off");
        dist_en = 1; cpu_en[1] = 0;
        step("R8 cpu1 off");

        // R10: banked state is per processor
        clear_all();
        set_priv(1, 2, 8'h10);
        priv_pend[0*32+2] = 0; priv_en[0*32+2] = 1;
        step("R10 banked");

        // Random sweep across all rules
        for (int n = 0; n < 400; n++) begin
            dist_en = ($urandom % 8) != 0;
            cpu_en = NC'($urandom);
            for (int c = 0; c < NC; c++) cpu_pmask[c*8 +: 8] = 8'($urandom % 4 == 0 ? 8'hFF : $urandom);
            for (int i = 0; i < NC*32; i++) begin
                priv_pend[i] = ($urandom % 6) == 0;
                priv_en[i]   = ($urandom % 3) != 0;
                priv_prio[i*8 +: 8] = 8'($urandom % 8 * 32);
            end
            for (int i = 0; i < NS; i++) begin
                spi_pend[i] = ($urandom % 5) == 0;
                spi_en[i]   = ($urandom % 3) != 0;
                spi_prio[i*8 +: 8] = 8'($urandom % 8 * 32);
                spi_tgt[i*8 +: 8]  = 8'($urandom);
            end
            rst_n = (n % 97) != 50;
            step("R2 R4 R5 random");
        end
        finish_run();
    end
endmodule